// File: doc/BRIEF.md
# DMA Controller Command, Request and Mask Register Block

This block serves the control port window of a four-channel DMA controller. A byte-wide bus writes to and reads from eight control locations. The block holds four things: the controller command byte, an eight-bit status byte, a four-bit channel mask and a mode byte for each channel. Writes to particular locations trigger actions:

- a software request for one channel,
- a single-bit mask update,
- a load of the whole mask,
- a clear of the whole mask,
- a clear of the byte-pointer flip-flop,
- a master clear.

The transfer sequencer reads the current mask, the four mode bytes and the pending request bits. It reports a finished transfer by pulsing a terminal-count bit for that channel. Peripherals can also raise or drop a channel's request bit directly.

The status byte has two halves. The upper nibble holds the pending requests, with bit 4+n for channel n. The lower nibble holds the terminal-count flags, with bit n for channel n. A status read returns the whole byte and then clears only the terminal-count half. The pending requests survive the read.

Top module: `dma_ctrl_regs`

## Requirements
- R1: After reset the command byte is 0, the mask is 4'hF (all channels masked), the status byte is 0 and every mode byte is 0.
- R2: The location index is addr[SHIFT+3:SHIFT]; address bits below SHIFT do not affect decoding. Index values 8 to 15 change no state on a write and read back as 0.
- R3: A write to index 0 loads the command byte only when the data is 0 or has no bit set other than bit 2 (value 8'h04). Any other value leaves the command byte unchanged.
- R4: A write to index 1 selects channel data[1:0]. It sets status bit 4+channel when data[2] is 1 and clears it when data[2] is 0. In every case it also clears status bit channel.
- R5: A write to index 2 sets mask bit data[1:0] when data[2] is 1 and clears it otherwise. The other mask bits keep their values.
- R6: A write to index 3 stores the whole data byte as the mode of channel data[1:0]. The mode of channel n appears on mode_o[8n+7:8n], with bits 3:2 as transfer type, bit 4 as auto-init, bit 5 as decrement and bits 7:6 as operating mode.
- R7: A write to index 4 drives ff_clear high during that write cycle only. A write to index 5 drives ff_clear and mclr_o high and then sets mask to 4'hF, status to 0 and command to 0. The mode bytes are left unchanged.
- R8: A write to index 6 clears all mask bits. A write to index 7 loads the mask from data[3:0].
- R9: While rd_en is high, index 0 returns the status byte and index 1 returns {4'h0, mask}; all other indices return 0. rdata is 0 while rd_en is low. After a read of index 0, status bits 3:0 are cleared and bits 7:4 keep their values.
- R10: A tc_set bit n sets status bit n at the next edge. It takes priority over a status read or an index 1 write in the same cycle, but not over a master clear.
- R11: A hold_req bit n sets status bit 4+n and a rel_req bit n clears it. When both are high, the hold wins. Both take priority over an index 1 write in the same cycle. req_o equals status bits 7:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control port write strobe |
| rd_en | input | 1 | Control port read strobe |
| addr | input | SHIFT+4 | Control port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| tc_set | input | 4 | Terminal-count pulses from the transfer sequencer |
| hold_req | input | 4 | Peripheral request raise, one bit per channel |
| rel_req | input | 4 | Peripheral request drop, one bit per channel |
| cmd_o | output | 8 | Command byte |
| mask_o | output | 4 | Channel mask |
| mode_o | output | 32 | Mode bytes, channel n at bits 8n+7:8n |
| req_o | output | 4 | Pending request bits (status bits 7:4) |
| ff_clear | output | 1 | Byte-pointer flip-flop clear pulse |
| mclr_o | output | 1 | Master clear pulse |

## Verification
The bench builds the block with SHIFT set to 1, the setting used for a word-spaced controller. This makes the bench drive real addresses with the low bit set and confirm that the bit is ignored. Indices 8 to 15 stay reachable through the four decoded bits, so the bench can show that writes to them change nothing and reads of them return 0. The bench also drives same-cycle collisions on the status byte: a terminal-count pulse during a status read, and a hold during a release.

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs #(
  parameter int SHIFT = 0,
  parameter logic [7:0] CMD_OK = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [SHIFT+3:0] addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic [3:0]       tc_set,
  input  logic [3:0]       hold_req,
  input  logic [3:0]       rel_req,
  output logic [7:0]       cmd_o,
  output logic [3:0]       mask_o,
  output logic [31:0]      mode_o,
  output logic [3:0]       req_o,
  output logic             ff_clear,
  output logic             mclr_o
);
  localparam int NCH = 4;

  logic [3:0] idx;
  logic [1:0] ch;
  logic [7:0] cmd_q, status_q, status_n;
  logic [3:0] mask_q, mask_n;
  logic [7:0] mode_q [NCH];
  logic       mclr;

  assign idx      = addr[SHIFT+3:SHIFT];
  assign ch       = wdata[1:0];
  assign mclr     = wr_en && idx == 4'd5;
  assign mclr_o   = mclr;
  assign ff_clear = wr_en && (idx == 4'd4 || idx == 4'd5);
  assign cmd_o    = cmd_q;
  assign mask_o   = mask_q;
  assign req_o    = status_q[7:4];

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_mode
      assign mode_o[8*g +: 8] = mode_q[g];
    end
  endgenerate

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (idx == 4'd0)      rdata = status_q;
      else if (idx == 4'd1) rdata = {4'h0, mask_q};
    end
  end

  always_comb begin
    status_n = status_q;
    if (rd_en && idx == 4'd0) status_n[3:0] = 4'h0;
    if (wr_en && idx == 4'd1) begin
      status_n[3'd4 + {1'b0, ch}] = wdata[2];
      status_n[{1'b0, ch}]        = 1'b0;
    end
    status_n[7:4] = (status_n[7:4] & ~rel_req) | hold_req;
    status_n[3:0] = status_n[3:0] | tc_set;
    if (mclr) status_n = 8'h00;
  end

  always_comb begin
    mask_n = mask_q;
    if (wr_en) begin
      case (idx)
        4'd2: mask_n[ch] = wdata[2];
        4'd5: mask_n = 4'hF;
        4'd6: mask_n = 4'h0;
        4'd7: mask_n = wdata[3:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= 8'h00;
      status_q <= 8'h00;
      mask_q   <= 4'hF;
      for (int i = 0; i < NCH; i++) mode_q[i] <= 8'h00;
    end else begin
      status_q <= status_n;
      mask_q   <= mask_n;
      if (mclr)
        cmd_q <= 8'h00;
      else if (wr_en && idx == 4'd0 && (wdata & ~CMD_OK) == 8'h00)
        cmd_q <= wdata;
      if (wr_en && idx == 4'd3) mode_q[ch] <= wdata;
    end
  end

  AST_CMD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd0 && (wdata & ~CMD_OK) != 8'h00) |=> $stable(cmd_o)); // R3
  AST_MASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_o == 4'hF && status_q == 8'h00 && cmd_o == 8'h00)); // R7
  AST_MASK_ALL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == 4'd6) |=> mask_o == 4'h0); // R8
  AST_STATUS_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && idx == 4'd0 && tc_set == 4'h0) |=> status_q[3:0] == 4'h0); // R9
  AST_TC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_set != 4'h0 && !mclr) |=> (status_q[3:0] & $past(tc_set)) == $past(tc_set)); // R10
  AST_HOLD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req != 4'h0 && !mclr) |=> (req_o & $past(hold_req)) == $past(hold_req)); // R11
endmodule

// File: tb/dma_ctrl_regs_tb.sv
module dma_ctrl_regs_tb;
  localparam int SHIFT = 1;
  localparam int NV = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [SHIFT+3:0] addr = '0;
  logic [7:0] wdata = 8'h00, rdata;
  logic [3:0] tc_set = 4'h0, hold_req = 4'h0, rel_req = 4'h0;
  logic [7:0] cmd_o;
  logic [3:0] mask_o, req_o;
  logic [31:0] mode_o;
  logic ff_clear, mclr_o;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  dma_ctrl_regs #(.SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tc_set(tc_set), .hold_req(hold_req),
    .rel_req(rel_req), .cmd_o(cmd_o), .mask_o(mask_o), .mode_o(mode_o),
    .req_o(req_o), .ff_clear(ff_clear), .mclr_o(mclr_o));

  // {is_read, index, data, expected read, requirement}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'd1, 8'h00, 8'h0F, 4'd1},   // R1 mask reset
    {1'b1, 4'd0, 8'h00, 8'h00, 4'd1},   // R1 status reset
    {1'b0, 4'd6, 8'h00, 8'h00, 4'd8},
    {1'b1, 4'd1, 8'h00, 8'h00, 4'd8},   // R8
    {1'b0, 4'd2, 8'h06, 8'h00, 4'd5},
    {1'b1, 4'd1, 8'h00, 8'h04, 4'd5},   // R5 set
    {1'b0, 4'd2, 8'h02, 8'h00, 4'd5},
    {1'b1, 4'd1, 8'h00, 8'h00, 4'd5},   // R5 clear
    {1'b0, 4'd7, 8'hFA, 8'h00, 4'd8},
    {1'b1, 4'd1, 8'h00, 8'h0A, 4'd8},   // R8 load
    {1'b0, 4'd1, 8'h05, 8'h00, 4'd4},
    {1'b1, 4'd0, 8'h00, 8'h20, 4'd4},   // R4 set request
    {1'b0, 4'd1, 8'h01, 8'h00, 4'd4},
    {1'b1, 4'd0, 8'h00, 8'h00, 4'd4},   // R4 clear request
    {1'b1, 4'd9, 8'h00, 8'h00, 4'd2},   // R2 high index
    {1'b1, 4'd2, 8'h00, 8'h00, 4'd9}    // R9 other index
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = (SHIFT+4)'(i) << SHIFT; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = (SHIFT+4)'(i) << SHIFT;
    #2 v = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog R0 actual=%0d cycles expected=finish", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd", cmd_o, 0); chk("R1 mask", mask_o, 4'hF);
    chk("R1 mode", mode_o, 0); chk("R1 req", req_o, 0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][24]) begin
        rd(VEC[k][23:20], v);
        chk($sformatf("R%0d vec%0d", VEC[k][3:0], k), v, VEC[k][11:4]);
      end else
        wr(VEC[k][23:20], VEC[k][19:12]);
    end

    // R3 command acceptance
    wr(0, 8'h04); chk("R3 accept", cmd_o, 8'h04);
    wr(0, 8'h10); chk("R3 reject", cmd_o, 8'h04);
    wr(0, 8'h05); chk("R3 reject mixed", cmd_o, 8'h04);
    wr(0, 8'h00); chk("R3 zero", cmd_o, 8'h00);

    // R6 mode bytes
    wr(3, 8'h56); chk("R6 ch2", mode_o[23:16], 8'h56);
    wr(3, 8'hFB); chk("R6 ch3", mode_o[31:24], 8'hFB);
    chk("R6 others", {mode_o[15:0]}, 16'h0);

    // R2 address low bit ignored, high index ignored
    wr(7, 8'h00);
    @(negedge clk); wr_en = 1; addr = 5'((2 << SHIFT) | 1); wdata = 8'h05;
    @(negedge clk); wr_en = 0;
    chk("R2 low addr bit", mask_o, 4'h2);
    wr(8, 8'h00); wr(14, 8'h00);
    chk("R2 high index write mask", mask_o, 4'h2);
    chk("R2 high index write cmd", cmd_o, 8'h00);

    // R7 flip-flop clear pulse
    @(negedge clk); wr_en = 1; addr = 5'(4 << SHIFT); wdata = 0;
    #2 chk("R7 ff_clear high", ff_clear, 1); chk("R7 no mclr", mclr_o, 0);
    @(negedge clk); wr_en = 0;
    #2 chk("R7 ff_clear low", ff_clear, 0);

    // R7 master clear
    wr(6, 0); wr(0, 8'h04); wr(1, 8'h06);
    chk("R7 pre req", req_o, 4'h4);
    @(negedge clk); wr_en = 1; addr = 5'(5 << SHIFT);
    #2 chk("R7 mclr pulse", {ff_clear, mclr_o}, 2'b11);
    @(negedge clk); wr_en = 0;
    chk("R7 mask", mask_o, 4'hF); chk("R7 cmd", cmd_o, 0);
    chk("R7 req", req_o, 0); chk("R7 mode kept", mode_o[23:16], 8'h56);

    // R10 terminal count and read clear
    @(negedge clk); tc_set = 4'b0010;
    @(negedge clk); tc_set = 4'h0;
    rd(0, v); chk("R10 tc set", v, 8'h02);
    rd(0, v); chk("R9 tc cleared by read", v, 8'h00);
    @(negedge clk); rd_en = 1; addr = 5'(0); tc_set = 4'b0001;
    #2 chk("R10 read sees old", rdata, 8'h00);
    @(negedge clk); rd_en = 0; tc_set = 0;
    rd(0, v); chk("R10 tc beats read clear", v, 8'h01);
    @(negedge clk); tc_set = 4'b1000;
    @(negedge clk); tc_set = 0;
    wr(1, 8'h03); rd(0, v); chk("R4 clears tc bit", v, 8'h00);

    // R11 hold / release
    @(negedge clk); hold_req = 4'b1001;
    @(negedge clk); hold_req = 0;
    chk("R11 hold", req_o, 4'b1001);
    rd(0, v); chk("R9 read returns req", v, 8'h90);
    rd(0, v); chk("R9 req survives read", v, 8'h90);
    @(negedge clk); hold_req = 4'b0001; rel_req = 4'b0001;
    @(negedge clk); hold_req = 0; rel_req = 0;
    chk("R11 hold wins", req_o, 4'b1001);
    @(negedge clk); rel_req = 4'b1001;
    @(negedge clk); rel_req = 0;
    chk("R11 release", req_o, 4'b0000);
    rd_en = 0;
    @(negedge clk); #2 chk("R9 idle rdata", rdata, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule